// File: doc/BRIEF.md
# Packet Buffer Memory Manager

This block owns the bookkeeping of a shared packet buffer in an Ethernet-style controller. Every buffer is one page tied to one packet number. A free bitmap records which numbers are available. A lowest-index search hands out numbers to two requesters: the host, through a command, and the receive engine, through a same-cycle request and grant. The data RAM itself sits outside the block. This block only decides which numbers are in use.

Packet numbers move through three queues. The host appends packets to the transmit queue. The transmit engine takes them from its head, and once each frame is sent it pushes the number into the completion queue, which the host drains. The receive engine pushes each filled buffer into the receive queue, and the host consumes them from its head. The host drives the block through a 3-bit command code and a packet-number field. The block answers with an allocation result, a busy flag while a release completes, a sticky error flag, and level interrupts for a non-empty receive queue and a non-empty completion queue.

Top module: `pktbuf_mgr`

## Requirements
- R1: After reset, busy, err, alloc_ok, alloc_fail, irq_rx, irq_tx and tx_req are all 0, and every packet number is free, so a receive request is granted packet number 0.
- R2: Command code 1 (allocate) takes the lowest free packet number. From the next cycle, alloc_ok is 1 and alloc_pnum holds that number. If no number is free, alloc_fail is 1 and alloc_ok is 0. The two flags are never 1 together.
- R3: When rx_alloc_req is high and a number is free, rx_alloc_gnt rises in the same cycle and rx_alloc_pnum is the lowest free number. If a host allocate is accepted in that same cycle, the host receives the next-lowest free number.
- R4: Command code 6 (enqueue) appends cmd_pnum to the transmit queue. While the queue is non-empty, tx_req is 1 and tx_pnum is the oldest entry. A cycle with tx_pop high removes that entry.
- R5: tx_done_valid pushes tx_done_pnum into the completion queue. irq_tx is 1 while that queue holds an entry, cq_head is its oldest entry, and cq_pop removes that entry.
- R6: rx_push_valid pushes rx_push_pnum into the receive queue, and irq_rx is 1 while the queue is non-empty. Command code 3 removes the head, and rx_head then shows the next entry. This command frees nothing.
- R7: Command code 4 removes the head of the receive queue and frees its packet number. busy is 1 for exactly the one cycle after the command, and the number can be allocated once busy has dropped.
- R8: Command code 5 frees the allocated packet named by cmd_pnum. busy is 1 for exactly the one cycle after the command.
- R9: Command code 7 empties the transmit queue and the completion queue, and frees no packet number.
- R10: Command code 2 is accepted even while busy. It frees every number, empties all three queues, and clears the allocation result, busy and err. In that cycle the receive request is not granted.
- R11: If command code 5 or 6 names a free packet number, the command is ignored and err is set. Any command other than codes 0 and 2 that arrives while busy is dropped and sets err. err stays set until command code 2 or reset.
- R12: Command code 3 or 4 issued while the receive queue is empty changes nothing except setting err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 3 | Command code (0 to 7) |
| cmd_pnum | input | PNW | Packet number for codes 5 and 6 |
| busy | output | 1 | A release is completing |
| err | output | 1 | Sticky command error |
| alloc_ok | output | 1 | Last host allocation succeeded (allocation interrupt) |
| alloc_fail | output | 1 | Last host allocation found the pool empty |
| alloc_pnum | output | PNW | Number granted by the last host allocation |
| rx_alloc_req | input | 1 | Receive engine requests a buffer |
| rx_alloc_gnt | output | 1 | Receive request granted this cycle |
| rx_alloc_pnum | output | PNW | Number granted to the receive engine |
| rx_push_valid | input | 1 | Receive engine pushes a filled buffer |
| rx_push_pnum | input | PNW | Number pushed to the receive queue |
| rx_head | output | PNW | Oldest entry of the receive queue |
| irq_rx | output | 1 | Receive queue not empty |
| tx_req | output | 1 | Transmit queue not empty |
| tx_pnum | output | PNW | Oldest entry of the transmit queue |
| tx_pop | input | 1 | Transmit engine takes the head |
| tx_done_valid | input | 1 | Transmit engine reports a sent frame |
| tx_done_pnum | input | PNW | Number of the sent frame |
| cq_head | output | PNW | Oldest entry of the completion queue |
| cq_pop | input | 1 | Host removes the completion head |
| irq_tx | output | 1 | Completion queue not empty |

## Verification
The host allocate command and the receive engine's grant can both take a number in the same cycle. The bench raises both in every cycle of a sweep that runs until the pool is empty. In each cycle it checks that the engine gets the lowest free number, that the host gets the next one, and that both requesters see exhaustion together at the end. A second overlap comes from a release and the command that follows it: a command issued in the busy cycle must be dropped and flagged as an error. Commands placed one cycle later must see the freed number again.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ALLOC    = 3'd1,
        OP_RESET    = 3'd2,
        OP_RX_DROP  = 3'd3,
        OP_RX_FREE  = 3'd4,
        OP_FREE     = 3'd5,
        OP_TX_PUSH  = 3'd6,
        OP_TX_FLUSH = 3'd7
    } op_e;
endpackage

// File: rtl/pktbuf_prio.sv
module pktbuf_prio #(
    parameter int N = 32
) (
    input  logic [N-1:0]         req,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // lowest set bit wins: scan downwards so the last hit is the lowest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pktbuf_queue.sv
module pktbuf_queue #(
    parameter int W     = 5,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t q_q, q_d;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    assign empty = (q_q.cnt == '0);
    assign full  = (q_q.cnt == CW'(DEPTH));
    assign head  = q_q.mem[q_q.rd];

    always_comb begin
        logic do_push, do_pop;
        q_d     = q_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            q_d.mem[q_q.wr] = push_data;
            q_d.wr          = step(q_q.wr);
        end
        if (do_pop) begin
            q_d.rd = step(q_q.rd);
        end
        if (do_push && !do_pop) begin
            q_d.cnt = q_q.cnt + CW'(1);
        end else if (do_pop && !do_push) begin
            q_d.cnt = q_q.cnt - CW'(1);
        end
        if (flush) begin
            q_d.rd  = '0;
            q_d.wr  = '0;
            q_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/pktbuf_mgr.sv
module pktbuf_mgr
    import pktbuf_pkg::*;
#(
    parameter int NPKT = 32,
    parameter int PNW  = $clog2(NPKT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_op,
    input  logic [PNW-1:0] cmd_pnum,
    output logic           busy,
    output logic           err,
    output logic           alloc_ok,
    output logic           alloc_fail,
    output logic [PNW-1:0] alloc_pnum,
    input  logic           rx_alloc_req,
    output logic           rx_alloc_gnt,
    output logic [PNW-1:0] rx_alloc_pnum,
    input  logic           rx_push_valid,
    input  logic [PNW-1:0] rx_push_pnum,
    output logic [PNW-1:0] rx_head,
    output logic           irq_rx,
    output logic           tx_req,
    output logic [PNW-1:0] tx_pnum,
    input  logic           tx_pop,
    input  logic           tx_done_valid,
    input  logic [PNW-1:0] tx_done_pnum,
    output logic [PNW-1:0] cq_head,
    input  logic           cq_pop,
    output logic           irq_tx
);
    typedef struct packed {
        logic [NPKT-1:0] free;
        logic            busy;
        logic [PNW-1:0]  pend;
        logic            err;
        logic            aok;
        logic            afail;
        logic [PNW-1:0]  apnum;
    } st_t;

    localparam st_t ST_INIT = '{free: '1, busy: 1'b0, pend: '0, err: 1'b0,
                                aok: 1'b0, afail: 1'b0, apnum: '0};

    st_t st_q, st_d;

    // pool search: first for the receive engine, second for the host
    logic            f0, f1;
    logic [PNW-1:0]  i0, i1;
    logic [NPKT-1:0] host_mask;
    logic            is_reset, rx_gnt;

    // queue controls
    logic txq_push, txq_flush, txq_empty, txq_full;
    logic rxq_pop, rxq_flush, rxq_empty, rxq_full;
    logic cq_flush, cq_empty, cq_full;

    assign is_reset = cmd_valid && (op_e'(cmd_op) == OP_RESET);
    assign rx_gnt   = rx_alloc_req && f0 && !is_reset;

    always_comb begin
        host_mask = st_q.free;
        if (rx_gnt) host_mask[i0] = 1'b0;
    end

    pktbuf_prio #(.N(NPKT)) u_prio_rx   (.req(st_q.free), .found(f0), .idx(i0));
    pktbuf_prio #(.N(NPKT)) u_prio_host (.req(host_mask), .found(f1), .idx(i1));

    always_comb begin
        logic act, drop;
        st_d      = st_q;
        txq_push  = 1'b0;
        txq_flush = 1'b0;
        rxq_pop   = 1'b0;
        rxq_flush = 1'b0;
        cq_flush  = 1'b0;
        act  = cmd_valid && !st_q.busy;
        drop = cmd_valid && st_q.busy && (op_e'(cmd_op) != OP_NOP) &&
               (op_e'(cmd_op) != OP_RESET);

        // a release started last cycle lands now
        if (st_q.busy) begin
            st_d.free[st_q.pend] = 1'b1;
            st_d.busy            = 1'b0;
        end
        if (rx_gnt) st_d.free[i0] = 1'b0;
        if (drop)   st_d.err      = 1'b1;

        if (act) begin
            unique case (op_e'(cmd_op))
                OP_ALLOC: begin
                    st_d.aok   = f1;
                    st_d.afail = !f1;
                    if (f1) begin
                        st_d.free[i1] = 1'b0;
                        st_d.apnum    = i1;
                    end
                end
                OP_RX_DROP: begin
                    if (rxq_empty) st_d.err = 1'b1;
                    else           rxq_pop  = 1'b1;
                end
                OP_RX_FREE: begin
                    if (rxq_empty) begin
                        st_d.err = 1'b1;
                    end else begin
                        rxq_pop   = 1'b1;
                        st_d.busy = 1'b1;
                        st_d.pend = rx_head;
                    end
                end
                OP_FREE: begin
                    if (st_q.free[cmd_pnum]) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.busy = 1'b1;
                        st_d.pend = cmd_pnum;
                    end
                end
                OP_TX_PUSH: begin
                    if (st_q.free[cmd_pnum] || txq_full) st_d.err = 1'b1;
                    else                                  txq_push = 1'b1;
                end
                OP_TX_FLUSH: begin
                    txq_flush = 1'b1;
                    cq_flush  = 1'b1;
                end
                default: ;
            endcase
        end

        if (is_reset) begin
            st_d      = ST_INIT;
            txq_flush = 1'b1;
            rxq_flush = 1'b1;
            cq_flush  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_INIT;
        else        st_q <= st_d;
    end

    pktbuf_queue #(.W(PNW), .DEPTH(NPKT)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(txq_flush),
        .push(txq_push), .push_data(cmd_pnum),
        .pop(tx_pop), .head(tx_pnum), .empty(txq_empty), .full(txq_full)
    );

    pktbuf_queue #(.W(PNW), .DEPTH(NPKT)) u_cq (
        .clk(clk), .rst_n(rst_n), .flush(cq_flush),
        .push(tx_done_valid), .push_data(tx_done_pnum),
        .pop(cq_pop), .head(cq_head), .empty(cq_empty), .full(cq_full)
    );

    pktbuf_queue #(.W(PNW), .DEPTH(NPKT)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rxq_flush),
        .push(rx_push_valid), .push_data(rx_push_pnum),
        .pop(rxq_pop), .head(rx_head), .empty(rxq_empty), .full(rxq_full)
    );

    logic unused_full;
    assign unused_full = cq_full ^ rxq_full;

    assign busy          = st_q.busy;
    assign err           = st_q.err;
    assign alloc_ok      = st_q.aok;
    assign alloc_fail    = st_q.afail;
    assign alloc_pnum    = st_q.apnum;
    assign rx_alloc_gnt  = rx_gnt;
    assign rx_alloc_pnum = i0;
    assign irq_rx        = !rxq_empty;
    assign tx_req        = !txq_empty;
    assign irq_tx        = !cq_empty;
endmodule

// File: rtl/pktbuf_mgr_chk.sv
module pktbuf_mgr_chk #(
    parameter int NPKT = 32,
    parameter int PNW  = $clog2(NPKT)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_valid,
    input logic [2:0]     cmd_op,
    input logic           busy,
    input logic           err,
    input logic           alloc_ok,
    input logic           alloc_fail,
    input logic [PNW-1:0] alloc_pnum,
    input logic           rx_alloc_gnt,
    input logic [PNW-1:0] rx_alloc_pnum,
    input logic           irq_rx,
    input logic           irq_tx,
    input logic           tx_req
);
    p_busy_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_result_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_ok && alloc_fail));

    p_distinct_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && !busy && rx_alloc_gnt)
        |=> (!alloc_ok || alloc_pnum != $past(rx_alloc_pnum)));

    p_rx_free_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4 && !busy && irq_rx) |=> busy);

    p_flush_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd7 && !busy) |=> (!tx_req && !irq_tx));

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2) |=>
        (!busy && !err && !alloc_ok && !alloc_fail && !irq_rx && !irq_tx && !tx_req));

    p_reset_no_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2) |-> !rx_alloc_gnt);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(cmd_valid && cmd_op == 3'd2)) |=> err);
endmodule

bind pktbuf_mgr pktbuf_mgr_chk #(.NPKT(NPKT), .PNW(PNW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .err(err), .alloc_ok(alloc_ok), .alloc_fail(alloc_fail),
    .alloc_pnum(alloc_pnum), .rx_alloc_gnt(rx_alloc_gnt),
    .rx_alloc_pnum(rx_alloc_pnum), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .tx_req(tx_req)
);

// File: tb/pktbuf_mgr_test.sv
module pktbuf_mgr_test;
    localparam int NPKT = 32;
    localparam int PNW  = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [2:0]     cmd_op = '0;
    logic [PNW-1:0] cmd_pnum = '0;
    logic           busy, err, alloc_ok, alloc_fail;
    logic [PNW-1:0] alloc_pnum;
    logic           rx_alloc_req = 1'b0;
    logic           rx_alloc_gnt;
    logic [PNW-1:0] rx_alloc_pnum;
    logic           rx_push_valid = 1'b0;
    logic [PNW-1:0] rx_push_pnum = '0;
    logic [PNW-1:0] rx_head;
    logic           irq_rx, tx_req;
    logic [PNW-1:0] tx_pnum;
    logic           tx_pop = 1'b0;
    logic           tx_done_valid = 1'b0;
    logic [PNW-1:0] tx_done_pnum = '0;
    logic [PNW-1:0] cq_head;
    logic           cq_pop = 1'b0;
    logic           irq_tx;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pktbuf_mgr #(.NPKT(NPKT)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pnum(cmd_pnum), .busy(busy), .err(err), .alloc_ok(alloc_ok),
        .alloc_fail(alloc_fail), .alloc_pnum(alloc_pnum),
        .rx_alloc_req(rx_alloc_req), .rx_alloc_gnt(rx_alloc_gnt),
        .rx_alloc_pnum(rx_alloc_pnum), .rx_push_valid(rx_push_valid),
        .rx_push_pnum(rx_push_pnum), .rx_head(rx_head), .irq_rx(irq_rx),
        .tx_req(tx_req), .tx_pnum(tx_pnum), .tx_pop(tx_pop),
        .tx_done_valid(tx_done_valid), .tx_done_pnum(tx_done_pnum),
        .cq_head(cq_head), .cq_pop(cq_pop), .irq_tx(irq_tx)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // all tasks start at a falling edge and end at the next one
    task automatic cmd(input int op, input int pn);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_pnum  = PNW'(pn);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic txpop_done(input int pn);
        tx_pop        = 1'b1;
        tx_done_valid = 1'b1;
        tx_done_pnum  = PNW'(pn);
        @(negedge clk);
        tx_pop        = 1'b0;
        tx_done_valid = 1'b0;
    endtask

    task automatic cqpop();
        cq_pop = 1'b1;
        @(negedge clk);
        cq_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 err", err, 0);
        chk("R1 alloc_ok", alloc_ok, 0);
        chk("R1 alloc_fail", alloc_fail, 0);
        chk("R1 irq_rx", irq_rx, 0);
        chk("R1 irq_tx", irq_tx, 0);
        chk("R1 tx_req", tx_req, 0);
        rx_alloc_req = 1'b1;
        #1;
        chk("R1 gnt", rx_alloc_gnt, 1);
        chk("R1 gnt pnum", rx_alloc_pnum, 0);
        rx_alloc_req = 1'b0;
        idle();

        // R2 full sweep of the pool, then exhaustion
        for (int i = 0; i < NPKT; i++) begin
            cmd(1, 0);
            chk("R2 ok", alloc_ok, 1);
            chk("R2 pnum", alloc_pnum, i);
        end
        cmd(1, 0);
        chk("R2 fail", alloc_fail, 1);
        chk("R2 ok when empty", alloc_ok, 0);

        // R10 reset command frees the pool
        cmd(2, 0);
        chk("R10 fail cleared", alloc_fail, 0);
        cmd(1, 0);
        chk("R10 realloc pnum", alloc_pnum, 0);

        // R11 release and enqueue of free numbers
        cmd(5, 5);
        chk("R11 free unallocated err", err, 1);
        chk("R11 no busy", busy, 0);
        cmd(6, 7);
        chk("R11 enqueue unallocated", tx_req, 0);
        cmd(2, 0);
        chk("R10 err cleared", err, 0);

        // R4 / R5 transmit and completion queues
        for (int i = 0; i < 4; i++) cmd(1, 0);
        chk("R4 alloc 3", alloc_pnum, 3);
        cmd(6, 2);
        cmd(6, 0);
        cmd(6, 3);
        chk("R4 tx_req", tx_req, 1);
        chk("R4 head", tx_pnum, 2);
        txpop_done(2);
        chk("R4 head after pop", tx_pnum, 0);
        chk("R5 irq_tx", irq_tx, 1);
        chk("R5 cq_head", cq_head, 2);
        txpop_done(0);
        chk("R4 head third", tx_pnum, 3);
        txpop_done(3);
        chk("R4 drained", tx_req, 0);
        cqpop();
        chk("R5 cq second", cq_head, 0);
        cqpop();
        chk("R5 cq third", cq_head, 3);
        cqpop();
        chk("R5 cq empty", irq_tx, 0);

        // R8 release with busy, R11 command during busy
        cmd(5, 2);
        chk("R8 busy", busy, 1);
        cmd(6, 0);
        chk("R11 busy drop err", err, 1);
        chk("R8 busy over", busy, 0);
        chk("R11 dropped enqueue", tx_req, 0);
        cmd(1, 0);
        chk("R8 freed number reused", alloc_pnum, 2);
        chk("R11 err sticky", err, 1);
        cmd(2, 0);

        // R3 simultaneous engine and host allocation sweep
        for (int k = 0; k < NPKT / 2; k++) begin
            rx_alloc_req = 1'b1;
            cmd_valid    = 1'b1;
            cmd_op       = 3'd1;
            #1;
            chk("R3 gnt", rx_alloc_gnt, 1);
            chk("R3 rx pnum", rx_alloc_pnum, 2 * k);
            @(negedge clk);
            rx_alloc_req = 1'b0;
            cmd_valid    = 1'b0;
            chk("R3 host pnum", alloc_pnum, 2 * k + 1);
        end
        rx_alloc_req = 1'b1;
        cmd_valid    = 1'b1;
        cmd_op       = 3'd1;
        #1;
        chk("R3 no gnt when empty", rx_alloc_gnt, 0);
        @(negedge clk);
        rx_alloc_req = 1'b0;
        cmd_valid    = 1'b0;
        chk("R3 host fail", alloc_fail, 1);

        // R10 reset command blocks the receive grant in its cycle
        rx_alloc_req = 1'b1;
        cmd_valid    = 1'b1;
        cmd_op       = 3'd2;
        #1;
        chk("R10 no gnt on reset", rx_alloc_gnt, 0);
        @(negedge clk);
        rx_alloc_req = 1'b0;
        cmd_valid    = 1'b0;

        // R6 / R7 / R12 receive queue
        for (int k = 0; k < 3; k++) begin
            rx_alloc_req  = 1'b1;
            rx_push_valid = 1'b1;
            rx_push_pnum  = PNW'(k);
            #1;
            chk("R6 rx alloc", rx_alloc_pnum, k);
            @(negedge clk);
            rx_alloc_req  = 1'b0;
            rx_push_valid = 1'b0;
        end
        chk("R6 irq_rx", irq_rx, 1);
        chk("R6 head", rx_head, 0);
        cmd(3, 0);
        chk("R6 next head", rx_head, 1);
        chk("R6 no busy", busy, 0);
        cmd(1, 0);
        chk("R6 nothing freed", alloc_pnum, 3);
        cmd(4, 0);
        chk("R7 busy", busy, 1);
        chk("R7 head", rx_head, 2);
        idle();
        chk("R7 busy one cycle", busy, 0);
        cmd(1, 0);
        chk("R7 freed reused", alloc_pnum, 1);
        cmd(4, 0);
        idle();
        chk("R6 empty irq", irq_rx, 0);
        chk("R12 no err yet", err, 0);
        cmd(3, 0);
        chk("R12 err", err, 1);
        chk("R12 busy", busy, 0);
        cmd(4, 0);
        chk("R12 rx free empty", busy, 0);
        cmd(1, 0);
        chk("R12 nothing freed", alloc_pnum, 2);

        // R9 flush of transmit queues
        cmd(2, 0);
        cmd(1, 0);
        cmd(1, 0);
        cmd(6, 0);
        cmd(6, 1);
        tx_done_valid = 1'b1;
        tx_done_pnum  = PNW'(1);
        idle();
        tx_done_valid = 1'b0;
        chk("R9 irq_tx before", irq_tx, 1);
        chk("R9 tx_req before", tx_req, 1);
        cmd(7, 0);
        chk("R9 tx_req flushed", tx_req, 0);
        chk("R9 irq_tx flushed", irq_tx, 0);
        cmd(1, 0);
        chk("R9 nothing freed", alloc_pnum, 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule